// File: doc/BRIEF.md
# Differential Data Word Coder

This block sits on a traced data bus and re-expresses every accepted data word as its distance from the word accepted before it. For each word it emits three fields together: a sign flag, the absolute distance, and how many 4-bit digits that distance needs once leading zero digits are dropped. A downstream packer can then store only the significant digits, which keeps the trace short when consecutive values are close.

The reference word starts at zero after reset, so the first word is coded against zero. Cycles without a valid input leave the reference untouched. One word can be accepted every cycle, and each coded item appears one clock after its input.

Top module: `delta_word_coder`

## Requirements
- R1: While reset is asserted and directly after it, out_valid is 0 and out_neg, out_mag and out_digits are all 0. The reference word is 0, so the first valid word W yields out_neg=0 and out_mag=W.
- R2: An item is presented with out_valid=1 exactly one clock edge after the edge that sampled in_valid=1. out_valid is 0 after any edge that sampled in_valid=0.
- R3: out_neg is 1 exactly when the current word, read as unsigned, is smaller than the reference word.
- R4: out_mag equals the unsigned absolute difference between the current word and the reference word over the full 32-bit range, with no wrap-around. For example 0 followed by 0xFFFFFFFF gives out_neg=0, out_mag=0xFFFFFFFF, and the reverse order gives out_neg=1, out_mag=0xFFFFFFFF.
- R5: out_digits is the position of the highest nonzero 4-bit digit of out_mag, counting from 1 at bits 3:0, up to 8 at bits 31:28. So 0xF gives 1, 0x10 gives 2 and 0x10000000 gives 8.
- R6: A word equal to the reference word gives out_digits=0, out_mag=0 and out_neg=0.
- R7: A cycle with in_valid=0 does not change the reference word, whatever in_data holds.
- R8: While out_valid is 0, out_neg, out_mag and out_digits keep their previous values.
- R9: Words presented on consecutive cycles are each coded against the word just before them, at one item per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_data holds a word to code |
| in_data | input | 32 | Data word |
| out_valid | output | 1 | Coded item present |
| out_neg | output | 1 | Difference is negative |
| out_mag | output | 32 | Absolute difference |
| out_digits | output | 4 | Significant 4-bit digits in out_mag, 0 to 8 |

## Verification
The bench drives words at both ends of the unsigned range. A coder that subtracted in only 32 bits would report the wrong sign or a wrapped magnitude there. It places magnitudes on digit boundaries such as 0xF, 0x10 and 0x10000000, where an off-by-one digit count would give a value one too high or one too low. Between valid words it drives garbage on in_data with valid low. A coder that updated its reference on every cycle would then code the next word against the wrong value, and one that did not hold its outputs would change them while out_valid is low. A long run of back-to-back words catches a reference that lags by a cycle.

// File: rtl/delta_word_coder.sv
module delta_word_coder #(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 4,
  localparam int NUM_DIGITS = DATA_W / DIGIT_W,
  localparam int CNT_W = $clog2(NUM_DIGITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_neg,
  output logic [DATA_W-1:0] out_mag,
  output logic [CNT_W-1:0]  out_digits
);

  logic [DATA_W-1:0]     ref_q;
  logic [DATA_W:0]       diff;
  logic                  neg;
  logic [DATA_W-1:0]     mag;
  logic [NUM_DIGITS-1:0] nz;
  logic [CNT_W-1:0]      cnt;

  // wide subtract keeps the borrow as the sign
  assign diff = {1'b0, in_data} - {1'b0, ref_q};
  assign neg  = diff[DATA_W];
  assign mag  = neg ? (ref_q - in_data) : diff[DATA_W-1:0];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_nz
    assign nz[g] = |mag[g*DIGIT_W +: DIGIT_W];
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_DIGITS; i++)
      if (nz[i]) cnt = CNT_W'(i + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q      <= '0;
      out_valid  <= 1'b0;
      out_neg    <= 1'b0;
      out_mag    <= '0;
      out_digits <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ref_q      <= in_data;
        out_neg    <= neg;
        out_mag    <= mag;
        out_digits <= cnt;
      end
    end
  end

endmodule

// File: rtl/delta_word_coder_chk.sv
module delta_word_coder_chk #(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 4,
  localparam int NUM_DIGITS = DATA_W / DIGIT_W,
  localparam int CNT_W = $clog2(NUM_DIGITS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic              out_neg,
  input logic [DATA_W-1:0] out_mag,
  input logic [CNT_W-1:0]  out_digits
);

  logic [63:0] mag64, hi_lim, lo_lim;
  assign mag64  = {{(64-DATA_W){1'b0}}, out_mag};
  assign hi_lim = (int'(out_digits) >= NUM_DIGITS) ? 64'd1 << DATA_W
                : 64'd1 << (int'(out_digits) * DIGIT_W);
  assign lo_lim = (out_digits == '0) ? 64'd0
                : 64'd1 << ((int'(out_digits) - 1) * DIGIT_W);

  always_comb if (!rst_n) AST_RESET_QUIET: assert (!out_valid); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_DIGITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_digits <= CNT_W'(NUM_DIGITS)); // R5
  AST_DIGITS_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (mag64 < hi_lim) && (mag64 >= lo_lim)); // R5
  AST_ZERO_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_digits == '0 |-> out_mag == '0 && !out_neg); // R6
  AST_NEG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_neg |-> out_mag != '0); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_mag) && $stable(out_neg) && $stable(out_digits)); // R8

endmodule

bind delta_word_coder delta_word_coder_chk #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_neg(out_neg), .out_mag(out_mag), .out_digits(out_digits));

// File: tb/test_delta_word_coder.sv
`timescale 1ns/1ps
module test_delta_word_coder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid, out_neg;
  logic [31:0] out_mag;
  logic [3:0]  out_digits;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] ref_w = '0;

  always #2.5 clk = ~clk;

  delta_word_coder i_delta_word_coder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_neg(out_neg), .out_mag(out_mag), .out_digits(out_digits));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] digits_of(input logic [31:0] m);
    logic [3:0] d = 0;
    for (int i = 0; i < 8; i++) if (m[i*4 +: 4] != 0) d = 4'(i + 1);
    return d;
  endfunction

  // present one word, check the coded item after the next edge
  task automatic send(input logic [31:0] w, input string req);
    logic        en;
    logic [31:0] em;
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    en = (w < ref_w);
    em = en ? ref_w - w : w - ref_w;
    @(posedge clk); #1;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " sign"},  64'(out_neg), 64'(en));
    check({req, " mag"},   64'(out_mag), 64'(em));
    check({req, " digits"}, 64'(out_digits), 64'(digits_of(em)));
    ref_w = w;
  endtask

  task automatic idle(input int n, input logic [31:0] junk);
    logic        pn;
    logic [31:0] pm;
    logic [3:0]  pd;
    @(negedge clk);
    pn = out_neg; pm = out_mag; pd = out_digits;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; in_data = junk ^ 32'(i * 32'h1357);
      @(posedge clk); #1;
      check("R2 idle valid", 64'(out_valid), 64'd0);
      check("R8 hold", {31'd0, out_neg, out_mag}, {31'd0, pn, pm});
      check("R8 hold digits", 64'(out_digits), 64'(pd));
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset valid", 64'(out_valid), 64'd0);
    check("R1 reset fields", {27'd0, out_neg, out_mag, out_digits}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 post-reset valid", 64'(out_valid), 64'd0);
    send(32'h0000_0005, "R1 first vs zero");
  endtask

  task automatic t_sign();
    send(32'h0000_1000, "R3 up");
    send(32'h0000_0FF0, "R3 down");
    send(32'h8000_0000, "R3 up big");
    send(32'h7FFF_FFFF, "R3 down by one");
    check("R3 neg flag", 64'(out_neg), 64'd1);
  endtask

  task automatic t_wrap();
    send(32'h0000_0000, "R4 to zero");
    send(32'hFFFF_FFFF, "R4 full up");
    check("R4 full up mag", 64'(out_mag), 64'hFFFF_FFFF);
    send(32'h0000_0000, "R4 full down");
    check("R4 full down sign", 64'(out_neg), 64'd1);
  endtask

  task automatic t_digits();
    send(32'h0000_000F, "R5 one digit");
    check("R5 0xF", 64'(out_digits), 64'd1);
    send(32'h0000_001F, "R5 two digits");
    check("R5 0x10", 64'(out_digits), 64'd2);
    send(32'h1000_001F, "R5 eight digits");
    check("R5 0x10000000", 64'(out_digits), 64'd8);
  endtask

  task automatic t_equal();
    send(32'hDEAD_BEEF, "R6 set");
    send(32'hDEAD_BEEF, "R6 same");
    check("R6 zero size", 64'(out_digits), 64'd0);
  endtask

  task automatic t_gap();
    send(32'h0000_0100, "R7 before gap");
    idle(4, 32'hA5A5_0000);
    send(32'h0000_0103, "R7 after gap");
    check("R7 kept ref", 64'(out_mag), 64'd3);
  endtask

  task automatic t_stream();
    logic [31:0] lf = 32'h1;
    for (int i = 0; i < 24; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      send((i % 3 == 0) ? lf : (ref_w + 32'(i * 7) - 32'd50), "R9 stream");
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    t_sign();
    t_wrap();
    t_digits();
    t_equal();
    t_gap();
    t_stream();
    idle(2, 32'h0F0F_F0F0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule